// File: doc/BRIEF.md
# Prioritized Interrupt Request Arbiter

The arbiter gathers interrupt requests from a fixed set of sources and gives each one a programmable 4-bit priority level. Every cycle it finds the single strongest request and compares its level with a 4-bit mask supplied by the processor's status register. An interrupt request goes to the processor, together with the winning level and the winning source index, only when that level is strictly above the mask. The processor uses the source index as its vector number.

Each source is set either to level mode or to edge mode. A level-mode source requests only while its input is high. An edge-mode source latches a rising edge as a pending flag. That flag stays set until the processor accepts the interrupt, until software clears it (for the low-numbered external sources), or until a reset. When two sources are tied on level, the fixed source order breaks the tie. The outputs are registered.

Top module: `irq_prio_arbiter`

## Requirements
- R1: Among the sources that are requesting, the one with the highest programmed level wins. `irq_lvl` reports its level and `irq_vec` its source index.
- R2: When several requesting sources share the top level, the source with the lowest index wins. This holds in both level and edge mode.
- R3: `irq_req` is 1 only when the winning level is strictly greater than `mask_lvl`. A source programmed to level 0 never requests.
- R4: In edge mode (`src_edge[i]`=1), a 0-to-1 transition of `src_req[i]` sets a pending flag. The flag keeps the source requesting after the input falls.
- R5: In level mode (`src_edge[i]`=0), a source requests only while `src_req[i]` is 1. Nothing is latched.
- R6: A cycle with `cpu_ack`=1 while `irq_req`=1 clears the pending flag of the source shown on `irq_vec`, and only that flag. Other pending sources are not affected.
- R7: A cycle with `ext_clr_en`=1 clears the pending flag of every source i < N_EXT whose bit `ext_clr_bits[i]` is 1. Sources whose bit is 0 keep their flag.
- R8: `rst_n`=0 clears all pending flags and all priority fields. A cycle with `dbg_rst`=1 clears all pending flags but keeps the priority fields.
- R9: All three outputs are registered. A change of `src_req` in level mode or of `mask_lvl` shows at the outputs one cycle later. A rising edge in edge mode shows two cycles later. A clear by acceptance or by software shows two cycles after the clearing cycle.
- R10: A cycle with `prio_wr_en`=1 loads `prio_wr_lvl` into the priority field of source `prio_wr_idx`. When no source is requesting, `irq_lvl` and `irq_vec` read 0. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| dbg_rst | input | 1 | Synchronous debug reset; clears pending flags |
| src_req | input | N_SRC | Request inputs, one per source |
| src_edge | input | N_SRC | Per-source mode: 1 = edge, 0 = level |
| prio_wr_en | input | 1 | Priority field write strobe |
| prio_wr_idx | input | IDX_W | Source whose priority field is written |
| prio_wr_lvl | input | 4 | Priority level to write |
| mask_lvl | input | 4 | Processor mask level |
| ext_clr_en | input | 1 | Software clear strobe for the external pending flags |
| ext_clr_bits | input | N_EXT | Write-one-to-clear bits, one per external source |
| cpu_ack | input | 1 | Processor accepts the current request |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_lvl | output | 4 | Level of the winning source |
| irq_vec | output | IDX_W | Index of the winning source (vector number) |

## Verification
In level mode, request and mask changes reach the outputs after one register. The bench drives these inputs just after a rising edge and samples one edge later. An edge-mode request needs two registers, the pending flag and then the output. For these the bench first checks that the outputs have not yet changed after one edge, and then checks the new winner after the second. After an acceptance, a software clear or a debug reset, the outputs still show the old state for one cycle. The bench therefore samples only after the second edge that follows the clearing cycle, and compares against its own pending model and its own ascending tie-break search.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int LVL_W = 4;
  typedef logic [LVL_W-1:0] lvl_t;

  // request goes out only when strictly above the mask
  function automatic logic beats_mask(lvl_t lvl, lvl_t mask);
    return lvl > mask;
  endfunction

  // scanning from high index to low; ">=" lets a lower index take a tie
  function automatic logic outranks(lvl_t cand, lvl_t best);
    return (cand != '0) && (cand >= best);
  endfunction
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(N_SRC)-1:0] wr_idx,
  input  lvl_t                     wr_lvl,
  output lvl_t [N_SRC-1:0]         prio_o
);
  lvl_t [N_SRC-1:0] prio_q;

  // R10: one field written per strobe; R8: cleared by power-on reset only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q <= '0;
    end else if (wr_en && (int'(wr_idx) < N_SRC)) begin
      prio_q[wr_idx] <= wr_lvl;
    end
  end

  assign prio_o = prio_q;
endmodule

// File: rtl/irq_pend_latch.sv
module irq_pend_latch #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] edge_mode,
  input  logic [N_SRC-1:0] clr,
  output logic [N_SRC-1:0] pend,
  output logic [N_SRC-1:0] rise,
  output logic [N_SRC-1:0] eff_req
);
  logic [N_SRC-1:0] src_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign rise[g]    = edge_mode[g] & src_req[g] & ~src_q[g];
    assign eff_req[g] = edge_mode[g] ? pend[g] : src_req[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        src_q[g] <= 1'b0;
        pend[g]  <= 1'b0;
      end else begin
        src_q[g] <= src_req[g];
        if (dbg_rst) pend[g] <= 1'b0;
        else         pend[g] <= edge_mode[g] & ((pend[g] & ~clr[g]) | rise[g]);
      end
    end

    assert_pend_hold_R4: assert property (@(posedge clk) disable iff (!rst_n || dbg_rst)
      (pend[g] && !clr[g] && edge_mode[g]) |=> pend[g]);

    assert_clear_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !rise[g]) |=> !pend[g]);
  end

  assert_dbg_wipe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_rst |=> (pend == '0));
endmodule

// File: rtl/irq_select.sv
module irq_select
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic [N_SRC-1:0]         eff_req,
  input  lvl_t [N_SRC-1:0]         prio,
  output logic                     win_valid,
  output lvl_t                     win_lvl,
  output logic [$clog2(N_SRC)-1:0] win_idx
);
  localparam int IDX_W = $clog2(N_SRC);

  always_comb begin
    win_lvl = '0;
    win_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (eff_req[i] && outranks(prio[i], win_lvl)) begin
        win_lvl = prio[i];
        win_idx = IDX_W'(i);
      end
    end
    win_valid = (win_lvl != '0);
  end
endmodule

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter
  import irq_arb_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int N_EXT = 2,
  localparam int IDX_W = $clog2(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbg_rst,
  input  logic [N_SRC-1:0] src_req,
  input  logic [N_SRC-1:0] src_edge,
  input  logic             prio_wr_en,
  input  logic [IDX_W-1:0] prio_wr_idx,
  input  logic [3:0]       prio_wr_lvl,
  input  logic [3:0]       mask_lvl,
  input  logic             ext_clr_en,
  input  logic [N_EXT-1:0] ext_clr_bits,
  input  logic             cpu_ack,
  output logic             irq_req,
  output logic [3:0]       irq_lvl,
  output logic [IDX_W-1:0] irq_vec
);
  lvl_t [N_SRC-1:0] prio;
  logic [N_SRC-1:0] pend, rise, eff_req;
  logic [N_SRC-1:0] ack_clr, sw_clr, clr_vec;
  logic             win_valid;
  lvl_t             win_lvl;
  logic [IDX_W-1:0] win_idx;

  irq_prio_regs #(.N_SRC(N_SRC)) prio_i (
    .clk(clk), .rst_n(rst_n), .wr_en(prio_wr_en),
    .wr_idx(prio_wr_idx), .wr_lvl(prio_wr_lvl), .prio_o(prio)
  );

  // R6: acceptance clears the displayed winner; R7: software clear for externals
  for (genvar g = 0; g < N_SRC; g++) begin : g_clr
    assign ack_clr[g] = cpu_ack & irq_req & (int'(irq_vec) == g);
    if (g < N_EXT) begin : g_ext
      assign sw_clr[g] = ext_clr_en & ext_clr_bits[g];
    end else begin : g_int
      assign sw_clr[g] = 1'b0;
    end
  end
  assign clr_vec = ack_clr | sw_clr;

  irq_pend_latch #(.N_SRC(N_SRC)) pend_i (
    .clk(clk), .rst_n(rst_n), .dbg_rst(dbg_rst), .src_req(src_req),
    .edge_mode(src_edge), .clr(clr_vec), .pend(pend), .rise(rise),
    .eff_req(eff_req)
  );

  irq_select #(.N_SRC(N_SRC)) sel_i (
    .eff_req(eff_req), .prio(prio), .win_valid(win_valid),
    .win_lvl(win_lvl), .win_idx(win_idx)
  );

  // R9: registered outputs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_req <= 1'b0;
      irq_lvl <= '0;
      irq_vec <= '0;
    end else begin
      irq_req <= win_valid && beats_mask(win_lvl, mask_lvl);
      irq_lvl <= win_lvl;
      irq_vec <= win_idx;
    end
  end

  assert_strict_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl > $past(mask_lvl)));

  assert_no_zero_level_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_lvl != 4'd0));

  assert_ack_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ack_clr) <= 1);
endmodule

// File: tb/irq_prio_arbiter_tb.sv
module irq_prio_arbiter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 8;
  localparam int NE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_rst = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic [NS-1:0] src_edge = '0;
  logic prio_wr_en = 1'b0;
  logic [2:0] prio_wr_idx = '0;
  logic [3:0] prio_wr_lvl = '0;
  logic [3:0] mask_lvl = '0;
  logic ext_clr_en = 1'b0;
  logic [NE-1:0] ext_clr_bits = '0;
  logic cpu_ack = 1'b0;
  logic irq_req;
  logic [3:0] irq_lvl;
  logic [2:0] irq_vec;

  int n_cmp = 0;
  int n_bad = 0;
  logic [3:0] bprio [NS];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_prio_arbiter #(.N_SRC(NS), .N_EXT(NE)) dut_i (
    .clk(clk), .rst_n(rst_n), .dbg_rst(dbg_rst), .src_req(src_req),
    .src_edge(src_edge), .prio_wr_en(prio_wr_en), .prio_wr_idx(prio_wr_idx),
    .prio_wr_lvl(prio_wr_lvl), .mask_lvl(mask_lvl), .ext_clr_en(ext_clr_en),
    .ext_clr_bits(ext_clr_bits), .cpu_ack(cpu_ack), .irq_req(irq_req),
    .irq_lvl(irq_lvl), .irq_vec(irq_vec)
  );

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic e_req, logic [3:0] e_lvl, logic [2:0] e_vec);
    n_cmp++;
    if (irq_req !== e_req || irq_lvl !== e_lvl || irq_vec !== e_vec) begin
      n_bad++;
      $display("FAIL %s: got req=%0d lvl=%0d vec=%0d, want req=%0d lvl=%0d vec=%0d",
               tag, irq_req, irq_lvl, irq_vec, e_req, e_lvl, e_vec);
    end
  endtask

  // ascending scan, strict compare: first (lowest) index keeps a tie
  task automatic expect_from(logic [NS-1:0] r, logic [3:0] m, string tag);
    logic [3:0] best = 0;
    logic [2:0] idx = 0;
    for (int i = 0; i < NS; i++) begin
      if (r[i] && bprio[i] > best) begin
        best = bprio[i];
        idx = 3'(i);
      end
    end
    chk(tag, best > m, best, idx);
  endtask

  task automatic set_prio(int i, logic [3:0] l);
    prio_wr_en = 1'b1; prio_wr_idx = 3'(i); prio_wr_lvl = l;
    step();
    prio_wr_en = 1'b0;
    bprio[i] = l;
  endtask

  task automatic pulse_edges(logic [NS-1:0] bits);
    src_req = bits; step();
    src_req = '0;   step();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R9 watchdog: got=timeout want=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) bprio[i] = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    chk("R10 reset state", 1'b0, 4'd0, 3'd0);

    // ties at 8 (sources 1,3) and 15 (sources 5,7); source 2 disabled by level 0
    set_prio(0, 3);  set_prio(1, 8); set_prio(2, 0);  set_prio(3, 8);
    set_prio(4, 5);  set_prio(5, 15); set_prio(6, 2); set_prio(7, 15);
    step();
    chk("R10 idle after prio writes", 1'b0, 4'd0, 3'd0);

    // level mode sweep: every request pattern against several masks (R1 R2 R3 R5 R9)
    for (int mi = 0; mi < 4; mi++) begin
      logic [3:0] m;
      m = (mi == 0) ? 4'd0 : (mi == 1) ? 4'd4 : (mi == 2) ? 4'd8 : 4'd15;
      for (int r = 0; r < 256; r++) begin
        src_req = 8'(r); mask_lvl = m;
        step();
        expect_from(8'(r), m, "R1/R2/R3 level sweep");
      end
    end

    mask_lvl = 4'd0;
    src_req = 8'h04; step();
    chk("R3 level zero never requests", 1'b0, 4'd0, 3'd0);
    src_req = 8'h20; step();
    chk("R5 level source requests", 1'b1, 4'd15, 3'd5);
    src_req = 8'h00; step();
    chk("R5 level source not latched", 1'b0, 4'd0, 3'd0);

    // R10: rewrite one field and see it take effect
    set_prio(4, 12);
    src_req = 8'h12; step();
    chk("R10 rewritten field", 1'b1, 4'd12, 3'd4);
    src_req = 8'h00;
    set_prio(4, 5);

    // edge mode
    src_edge = '1; step(); step();
    chk("R4 edge idle", 1'b0, 4'd0, 3'd0);
    src_req = 8'h10; step();
    chk("R9 edge not yet visible", 1'b0, 4'd0, 3'd0);
    step();
    chk("R9 edge visible after two", 1'b1, 4'd5, 3'd4);
    src_req = 8'h00; step(); step(); step();
    chk("R4 pending held after input falls", 1'b1, 4'd5, 3'd4);
    src_req = 8'h42; step();
    src_req = 8'h00; step();
    chk("R1 edge strongest", 1'b1, 4'd8, 3'd1);

    // R6 acceptance clears only the winner
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0; step();
    chk("R6 ack clears winner only", 1'b1, 4'd5, 3'd4);
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0; step();
    chk("R6 next pending", 1'b1, 4'd2, 3'd6);
    mask_lvl = 4'd2; step();
    chk("R3 equal to mask rejected", 1'b0, 4'd2, 3'd6);
    mask_lvl = 4'd1; step();
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0; step();
    chk("R6 all cleared", 1'b0, 4'd0, 3'd0);
    mask_lvl = 4'd0;

    // R7 software clear of external pendings
    pulse_edges(8'h03); step();
    chk("R7 setup", 1'b1, 4'd8, 3'd1);
    ext_clr_en = 1'b1; ext_clr_bits = 2'b10; step();
    ext_clr_en = 1'b0; ext_clr_bits = 2'b00; step();
    chk("R7 cleared source 1, source 0 kept", 1'b1, 4'd3, 3'd0);
    pulse_edges(8'h10); step();
    ext_clr_en = 1'b1; ext_clr_bits = 2'b01; step();
    ext_clr_en = 1'b0; ext_clr_bits = 2'b00; step();
    chk("R7 cleared source 0, source 4 kept", 1'b1, 4'd5, 3'd4);
    cpu_ack = 1'b1; step(); cpu_ack = 1'b0; step();
    chk("R6 drain", 1'b0, 4'd0, 3'd0);

    // R2 tie in edge mode, then R8 debug reset
    pulse_edges(8'hA0); step();
    chk("R2 edge tie lowest index", 1'b1, 4'd15, 3'd5);
    dbg_rst = 1'b1; step(); dbg_rst = 1'b0; step();
    chk("R8 debug reset clears pendings", 1'b0, 4'd0, 3'd0);
    pulse_edges(8'h80); step();
    chk("R8 priorities kept over debug reset", 1'b1, 4'd15, 3'd7);

    // R8 power-on reset clears priorities as well
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    chk("R8 power-on reset", 1'b0, 4'd0, 3'd0);
    for (int i = 0; i < NS; i++) bprio[i] = 0;
    src_edge = '0; src_req = 8'hFF; step();
    expect_from(8'hFF, 4'd0, "R8 priorities zero after reset");
    src_req = '0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule